// File: doc/BRIEF.md
# Slot-Aligned Serial Delay-Line Word Store

This block is a word memory built from serial recirculating lines. A bank of long lines each holds a fixed number of words. All long lines turn in lockstep, so word n of every line passes the shared gating point in the same bit times. A set of short lines each holds a single word and repeats it once every word time. A free-running slot counter names the bit and word that is passing the gate in each cycle. Bits leave each line least significant first.

A controller takes one move command at a time: a source code, a destination code and a word position. It waits until that word position comes round. For one word time it then steers the source bit stream into the destination line, and in the cycle after the last bit it pulses done. A long-to-long move can only keep a word at the same position. To put a word at another position, move it into a short line first, then move it out while the target position passes. A serial input can act as a source, which is how words are loaded. The current bit of every line is visible at the ports, which is how contents are read.

Line codes: 0 to 9 select the long lines, 10 to 15 select the short lines, and 16 selects the serial input (source only).

Top module: `dl_word_store`

## Requirements
- R1: After reset the slot bit index and slot word index are both 0. The bit index rises by one every cycle and wraps from 31 to 0. The word index rises by one at each bit wrap and wraps from 31 to 0.
- R2: During slot (w, b), output bit L of `long_bits_o` shows bit b (bit 0 = LSB) of word w of long line L. All contents are zero after reset.
- R3: `cmd_ready_o` is high while idle. A command is taken on a cycle with valid and ready both high. Ready then stays low until the done cycle has passed.
- R4: A taken command transfers during the first 32 cycles after acceptance that run from slot (pos, 0) to slot (pos, 31). Word pos of the destination then equals the source word: for a long source, its word pos; for a short source, its single word.
- R5: `done_o` is high for exactly one cycle, right after slot (pos, 31). Counting from the acceptance edge, with c0 = 32*word+bit at acceptance, done is seen in cycle ((32*pos - c0 - 1) mod 1024) + 33.
- R6: Every line other than the destination, and every other word of a long destination, keeps its contents through a move.
- R7: A move whose source equals its destination leaves all contents unchanged.
- R8: A short line (codes 10..15) shows bit b of its word on `temp_bits_o` during every slot with bit index b, whatever the word index. As a destination it captures the source word while pos passes. As a source it can be written to any position of a long line, which allows reordering.
- R9: Source code 16 takes `ext_bit_i` as sampled in each transfer cycle. Destination codes of 16 or above write nothing. Source codes above 16 supply zeros. Such moves still complete with done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid_i | input | 1 | Move command present |
| cmd_ready_o | output | 1 | Controller idle, command can be taken |
| cmd_src_i | input | 5 | Source line code |
| cmd_dst_i | input | 5 | Destination line code |
| cmd_pos_i | input | 5 | Word position of the move |
| done_o | output | 1 | One-cycle pulse after the last transferred bit |
| ext_bit_i | input | 1 | Serial input used by source code 16 |
| slot_word_o | output | 5 | Word index now at the gate |
| slot_bit_o | output | 5 | Bit index now at the gate |
| long_bits_o | output | 10 | Current bit of each long line |
| temp_bits_o | output | 6 | Current bit of each short line |

## Verification
The assertions assume that the command fields are held stable only at acceptance, because the controller latches them then. They assume the serial input is meaningful only while a code 16 transfer runs. They also assume the word and bit counts let the slot counter wrap cleanly. The bench drives command fields only at the clock's falling edge and drops valid right after acceptance. It drives the serial input from the published bit index, so each input bit lines up with the slot that consumes it. Random line codes are drawn from the defined range. Destination and source codes beyond that range appear only in directed cases.

// File: rtl/dlstore_pkg.sv
package dlstore_pkg;
    localparam int N_LONG_DEF = 10;
    localparam int N_TEMP_DEF = 6;
    localparam int N_WORD_DEF = 32;
    localparam int W_BITS_DEF = 32;

    typedef enum logic [1:0] {
        MV_IDLE = 2'd0,
        MV_WAIT = 2'd1,
        MV_XFER = 2'd2,
        MV_DONE = 2'd3
    } mv_state_e;
endpackage

// File: rtl/dl_slot_timer.sv
module dl_slot_timer #(
    parameter int N_WORD = 32,
    parameter int W_BITS = 32,
    localparam int WORD_W = $clog2(N_WORD),
    localparam int BIT_W  = $clog2(W_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [WORD_W-1:0] word_o,
    output logic [BIT_W-1:0]  bit_o
);
    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [BIT_W-1:0]  bitn;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (slot_q.bitn == BIT_W'(W_BITS - 1)) begin
            slot_d.bitn = '0;
            slot_d.word = (slot_q.word == WORD_W'(N_WORD - 1)) ? '0 : slot_q.word + 1'b1;
        end else begin
            slot_d.bitn = slot_q.bitn + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign word_o = slot_q.word;
    assign bit_o  = slot_q.bitn;

    assert_bit_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q.bitn == BIT_W'(W_BITS - 1)) |=> (slot_q.bitn == '0) &&
        (slot_q.word == (($past(slot_q.word) == WORD_W'(N_WORD - 1)) ? '0 : $past(slot_q.word) + 1'b1)));

    assert_bit_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q.bitn != BIT_W'(W_BITS - 1)) |=> (slot_q.bitn == $past(slot_q.bitn) + 1'b1) && $stable(slot_q.word));
endmodule

// File: rtl/dl_line.sv
module dl_line #(
    parameter int SLOTS  = 32,
    parameter int W_BITS = 32,
    localparam int IW    = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int BIT_W = $clog2(W_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IW-1:0]    word_i,
    input  logic [BIT_W-1:0] bit_i,
    input  logic             we_i,
    input  logic             d_i,
    output logic             q_o
);
    logic [W_BITS-1:0] mem_d [SLOTS];
    logic [W_BITS-1:0] mem_q [SLOTS];

    always_comb begin
        mem_d = mem_q;
        if (we_i) mem_d[word_i][bit_i] = d_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SLOTS; s++) mem_q[s] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign q_o = mem_q[word_i][bit_i];

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> mem_q[$past(word_i)][$past(bit_i)] == $past(q_o));

    assert_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> mem_q[$past(word_i)][$past(bit_i)] == $past(d_i));
endmodule

// File: rtl/dl_move_ctrl.sv
module dl_move_ctrl
    import dlstore_pkg::*;
#(
    parameter int N_LONG = 10,
    parameter int N_TEMP = 6,
    parameter int N_WORD = 32,
    parameter int W_BITS = 32,
    localparam int EXT_CODE = N_LONG + N_TEMP,
    localparam int CODE_W   = $clog2(EXT_CODE + 1),
    localparam int WORD_W   = $clog2(N_WORD),
    localparam int BIT_W    = $clog2(W_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid_i,
    output logic              cmd_ready_o,
    input  logic [CODE_W-1:0] cmd_src_i,
    input  logic [CODE_W-1:0] cmd_dst_i,
    input  logic [WORD_W-1:0] cmd_pos_i,
    output logic              done_o,
    input  logic [WORD_W-1:0] word_i,
    input  logic [BIT_W-1:0]  bit_i,
    input  logic [N_LONG-1:0] long_q_i,
    input  logic [N_TEMP-1:0] temp_q_i,
    input  logic              ext_bit_i,
    output logic [N_LONG-1:0] long_we_o,
    output logic [N_TEMP-1:0] temp_we_o,
    output logic              wr_bit_o
);
    typedef struct packed {
        mv_state_e         st;
        logic [CODE_W-1:0] src;
        logic [CODE_W-1:0] dst;
        logic [WORD_W-1:0] pos;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic gate;
    logic src_bit;

    always_comb begin
        src_bit = 1'b0;
        for (int i = 0; i < N_LONG; i++)
            if (ctl_q.src == CODE_W'(i)) src_bit = long_q_i[i];
        for (int i = 0; i < N_TEMP; i++)
            if (ctl_q.src == CODE_W'(N_LONG + i)) src_bit = temp_q_i[i];
        if (ctl_q.src == CODE_W'(EXT_CODE)) src_bit = ext_bit_i;
    end

    always_comb begin
        ctl_d = ctl_q;
        gate  = 1'b0;
        unique case (ctl_q.st)
            MV_IDLE: begin
                if (cmd_valid_i) begin
                    ctl_d.st  = MV_WAIT;
                    ctl_d.src = cmd_src_i;
                    ctl_d.dst = cmd_dst_i;
                    ctl_d.pos = cmd_pos_i;
                end
            end
            MV_WAIT: begin
                if (word_i == ctl_q.pos && bit_i == '0) begin
                    gate     = 1'b1;
                    ctl_d.st = MV_XFER;
                end
            end
            MV_XFER: begin
                gate = 1'b1;
                if (bit_i == BIT_W'(W_BITS - 1)) ctl_d.st = MV_DONE;
            end
            MV_DONE: ctl_d.st = MV_IDLE;
            default: ctl_d.st = MV_IDLE;
        endcase
    end

    generate
        for (genvar g = 0; g < N_LONG; g++) begin : g_lwe
            assign long_we_o[g] = gate && (ctl_q.dst == CODE_W'(g));
        end
        for (genvar g = 0; g < N_TEMP; g++) begin : g_twe
            assign temp_we_o[g] = gate && (ctl_q.dst == CODE_W'(N_LONG + g));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '{st: MV_IDLE, src: '0, dst: '0, pos: '0};
        else        ctl_q <= ctl_d;
    end

    assign wr_bit_o    = src_bit;
    assign cmd_ready_o = (ctl_q.st == MV_IDLE);
    assign done_o      = (ctl_q.st == MV_DONE);

    assert_one_dest_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({long_we_o, temp_we_o}));

    assert_xfer_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == MV_XFER) |-> (word_i == ctl_q.pos) && (bit_i != '0));

    assert_busy_after_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && cmd_ready_o) |=> !cmd_ready_o);

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o && cmd_ready_o);

    assert_done_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> ($past(bit_i) == BIT_W'(W_BITS - 1)) && ($past(word_i) == ctl_q.pos));
endmodule

// File: rtl/dl_word_store.sv
module dl_word_store
    import dlstore_pkg::*;
#(
    parameter int N_LONG = N_LONG_DEF,
    parameter int N_TEMP = N_TEMP_DEF,
    parameter int N_WORD = N_WORD_DEF,
    parameter int W_BITS = W_BITS_DEF,
    localparam int CODE_W = $clog2(N_LONG + N_TEMP + 1),
    localparam int WORD_W = $clog2(N_WORD),
    localparam int BIT_W  = $clog2(W_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid_i,
    output logic              cmd_ready_o,
    input  logic [CODE_W-1:0] cmd_src_i,
    input  logic [CODE_W-1:0] cmd_dst_i,
    input  logic [WORD_W-1:0] cmd_pos_i,
    output logic              done_o,
    input  logic              ext_bit_i,
    output logic [WORD_W-1:0] slot_word_o,
    output logic [BIT_W-1:0]  slot_bit_o,
    output logic [N_LONG-1:0] long_bits_o,
    output logic [N_TEMP-1:0] temp_bits_o
);
    logic [WORD_W-1:0] word_c;
    logic [BIT_W-1:0]  bit_c;
    logic [N_LONG-1:0] long_we;
    logic [N_TEMP-1:0] temp_we;
    logic              wr_bit;

    dl_slot_timer #(.N_WORD(N_WORD), .W_BITS(W_BITS)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .word_o (word_c),
        .bit_o  (bit_c)
    );

    generate
        for (genvar g = 0; g < N_LONG; g++) begin : g_long
            dl_line #(.SLOTS(N_WORD), .W_BITS(W_BITS)) u_line (
                .clk    (clk),
                .rst_n  (rst_n),
                .word_i (word_c),
                .bit_i  (bit_c),
                .we_i   (long_we[g]),
                .d_i    (wr_bit),
                .q_o    (long_bits_o[g])
            );
        end
        for (genvar g = 0; g < N_TEMP; g++) begin : g_temp
            dl_line #(.SLOTS(1), .W_BITS(W_BITS)) u_line (
                .clk    (clk),
                .rst_n  (rst_n),
                .word_i (1'b0),
                .bit_i  (bit_c),
                .we_i   (temp_we[g]),
                .d_i    (wr_bit),
                .q_o    (temp_bits_o[g])
            );
        end
    endgenerate

    dl_move_ctrl #(
        .N_LONG (N_LONG),
        .N_TEMP (N_TEMP),
        .N_WORD (N_WORD),
        .W_BITS (W_BITS)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid_i (cmd_valid_i),
        .cmd_ready_o (cmd_ready_o),
        .cmd_src_i   (cmd_src_i),
        .cmd_dst_i   (cmd_dst_i),
        .cmd_pos_i   (cmd_pos_i),
        .done_o      (done_o),
        .word_i      (word_c),
        .bit_i       (bit_c),
        .long_q_i    (long_bits_o),
        .temp_q_i    (temp_bits_o),
        .ext_bit_i   (ext_bit_i),
        .long_we_o   (long_we),
        .temp_we_o   (temp_we),
        .wr_bit_o    (wr_bit)
    );

    assign slot_word_o = word_c;
    assign slot_bit_o  = bit_c;
endmodule

// File: tb/tb_dl_word_store.sv
module tb_dl_word_store;
    localparam int NL = 10;
    localparam int NT = 6;
    localparam int NW = 32;
    localparam int WB = 32;
    localparam int EXT = NL + NT;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [4:0]  cmd_src = '0;
    logic [4:0]  cmd_dst = '0;
    logic [4:0]  cmd_pos = '0;
    logic        done;
    logic        ext_bit;
    logic [4:0]  slot_word;
    logic [4:0]  slot_bit;
    logic [NL-1:0] long_bits;
    logic [NT-1:0] temp_bits;
    logic [31:0] ext_word = '0;

    int vectors = 0;
    int fails = 0;
    bit finished = 0;

    logic [31:0] m_long [NL][NW];
    logic [31:0] m_temp [NT];
    logic [31:0] cap_long [NL][NW];
    logic [31:0] cap_temp [NT];

    always #4 clk = ~clk;

    assign ext_bit = ext_word[slot_bit];

    dl_word_store dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
        .cmd_src_i(cmd_src), .cmd_dst_i(cmd_dst), .cmd_pos_i(cmd_pos), .done_o(done),
        .ext_bit_i(ext_bit), .slot_word_o(slot_word), .slot_bit_o(slot_bit),
        .long_bits_o(long_bits), .temp_bits_o(temp_bits)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int exp_latency(input int pos, input int c0);
        return (((pos * WB - c0 - 1) % (NW * WB)) + NW * WB) % (NW * WB) + WB + 1;
    endfunction

    function automatic logic [31:0] src_word(input int src, input int pos);
        if (src < NL) return m_long[src][pos];
        if (src < NL + NT) return m_temp[src - NL];
        if (src == EXT) return ext_word;
        return '0;
    endfunction

    task automatic do_move(input int src, input int dst, input int pos, input bit align,
                           input string tag);
        int c0;
        int n;
        logic [31:0] w;
        @(negedge clk);
        if (align)
            while (!(slot_word == 5'((pos + NW - 1) % NW) && slot_bit == 5'(WB - 1))) @(negedge clk);
        chk({"R3 ready idle ", tag}, cmd_ready, 1);
        cmd_valid = 1'b1;
        cmd_src = 5'(src);
        cmd_dst = 5'(dst);
        cmd_pos = 5'(pos);
        c0 = int'(slot_word) * WB + int'(slot_bit);
        w = src_word(src, pos);
        @(posedge clk);
        #1 cmd_valid = 1'b0;
        @(negedge clk);
        n = 1;
        chk({"R3 ready low ", tag}, cmd_ready, 0);
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk({"R5 latency ", tag}, n, exp_latency(pos, c0));
        @(negedge clk);
        chk({"R5 done pulse ", tag}, done, 0);
        if (dst < NL) m_long[dst][pos] = w;
        else if (dst < NL + NT) m_temp[dst - NL] = w;
    endtask

    task automatic dump_check(input string tag);
        @(negedge clk);
        while (!(slot_word == 0 && slot_bit == 0)) @(negedge clk);
        for (int k = 0; k < NW * WB; k++) begin
            for (int l = 0; l < NL; l++) cap_long[l][k / WB][k % WB] = long_bits[l];
            if (k < WB) for (int t = 0; t < NT; t++) cap_temp[t][k] = temp_bits[t];
            if (k >= (NW - 1) * WB)
                for (int t = 0; t < NT; t++)
                    if (cap_temp[t][k % WB] !== temp_bits[t]) begin
                        fails++;
                        $display("FAIL R8 temp %0d repeat bit %0d got %0b expected %0b",
                                 t, k % WB, temp_bits[t], cap_temp[t][k % WB]);
                    end
            @(negedge clk);
        end
        for (int l = 0; l < NL; l++)
            for (int w = 0; w < NW; w++)
                chk($sformatf("R2/R6 %s line %0d word %0d", tag, l, w), cap_long[l][w], m_long[l][w]);
        for (int t = 0; t < NT; t++)
            chk($sformatf("R8 %s temp %0d", tag, t), cap_temp[t], m_temp[t]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        int prev;
        void'($urandom(32'd4242));
        for (int l = 0; l < NL; l++) for (int w = 0; w < NW; w++) m_long[l][w] = '0;
        for (int t = 0; t < NT; t++) m_temp[t] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 / R3 reset state (one cycle after release)
        chk("R1 reset word", slot_word, 0);
        chk("R1 reset bit", slot_bit, 1);
        chk("R3 reset ready", cmd_ready, 1);
        chk("R5 reset done", done, 0);
        chk("R2 reset long bits", long_bits, 0);
        chk("R8 reset temp bits", temp_bits, 0);
        // R1 counter stepping across a word wrap
        prev = int'(slot_word) * WB + int'(slot_bit);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            chk("R1 slot step", int'(slot_word) * WB + int'(slot_bit), (prev + 1) % (NW * WB));
            prev = (prev + 1) % (NW * WB);
        end
        // R9 loads from serial input, including edge positions
        for (int l = 0; l < NL; l++) begin
            for (int j = 0; j < 3; j++) begin
                int p;
                p = (j == 0) ? 0 : (j == 1) ? NW - 1 : int'($urandom_range(1, NW - 2));
                ext_word = $urandom;
                do_move(EXT, l, p, 1'b0, "R9 load");
            end
        end
        for (int t = 0; t < NT; t++) begin
            ext_word = $urandom;
            do_move(EXT, NL + t, int'($urandom_range(0, NW - 1)), 1'b0, "R9 temp load");
        end
        dump_check("after load");
        // R4 directed: zero wait when accepted just before the slot
        do_move(3, 4, 0, 1'b1, "R4 aligned pos0");
        do_move(0, 9, NW - 1, 1'b1, "R4 aligned pos31");
        // R7 source equals destination
        do_move(5, 5, 0, 1'b0, "R7 self");
        do_move(NL + 2, NL + 2, 7, 1'b0, "R7 temp self");
        // R9 destination beyond range writes nothing; high source gives zeros
        ext_word = 32'hFFFF_FFFF;
        do_move(EXT, EXT, 3, 1'b0, "R9 dst ext");
        do_move(EXT, 29, 4, 1'b0, "R9 dst out of range");
        do_move(20, 6, NW - 1, 1'b0, "R9 zero source");
        // R4 same-position random long moves
        for (int i = 0; i < 20; i++)
            do_move(int'($urandom_range(0, NL - 1)), int'($urandom_range(0, NL - 1)),
                    int'($urandom_range(0, NW - 1)), 1'b0, "R4 random");
        dump_check("after moves");
        // R8 reorder through a short line
        do_move(2, NL + 1, 0, 1'b0, "R8 stage");
        do_move(NL + 1, 7, NW - 1, 1'b0, "R8 place");
        do_move(8, NL + 5, 13, 1'b1, "R8 stage aligned");
        do_move(NL + 5, 8, 2, 1'b0, "R8 place back");
        // mixed random traffic including short lines
        for (int i = 0; i < 20; i++)
            do_move(int'($urandom_range(0, NL + NT - 1)), int'($urandom_range(0, NL + NT - 1)),
                    int'($urandom_range(0, NW - 1)), 1'b0, "R8 mixed");
        dump_check("final");
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule